// File: doc/BRIEF.md
# Reference Divider and Phase/Frequency Detector Control

This block sits between a crystal-clocked reference chain and the charge pump of a frequency synthesizer loop. It divides the crystal clock by one of two ratios to make the comparison reference. A three-state phase/frequency detector then compares that reference with a one-cycle pulse from the feedback divider, and produces up and down pump enables.

A seven-bit control word and a five-bit band word, held in registers outside the block, shape the outputs:
- Two control bits select the reference ratio.
- Two control bits force the detector into normal, off, up-only or down-only behaviour.
- One control bit sets the pump current.
- One control bit disables the loop amplifier.
- One control bit routes the internal reference and the halved feedback onto two of the band outputs for test.

All logic runs on the crystal clock. The feedback pulse and the halved feedback level are expected to be synchronous to that clock.

Top module: `refpd_ctrl`

## Requirements
- R1: The reference ratio is LO_RATIO when control bit 2 equals control bit 3, and HI_RATIO when they differ. The reference level repeats every ratio clock cycles and is high for the first half of each period.
- R2: A change of the ratio bits in the middle of a period leaves the length and the high time of the current period unchanged. The new ratio applies from the next period.
- R3: In normal mode, a reference terminal count with nothing pending asserts pump_up from the next cycle until a feedback pulse arrives. A feedback pulse with nothing pending asserts pump_dn until the next reference terminal count.
- R4: When both a reference event and a feedback event are pending, both enables clear on the next clock. A reference event and a feedback pulse in the same cycle assert neither enable. A repeated event on the side already pending leaves the state unchanged.
- R5: The detector mode is set by {ctrl[1], ctrl[4]}: 2'b10 is normal, 2'b11 forces both enables low, 2'b00 holds pump_up high and pump_dn low, and 2'b01 holds pump_dn high and pump_up low. Forced modes ignore all edges.
- R6: While the mode is not normal, the detector state is held clear, so a return to normal mode starts with both enables low.
- R7: pump_hi follows ctrl[6] (1 selects the high pump current). amp_off follows ctrl[0] (1 disables the amplifier).
- R8: With ctrl[5] at 0, band_on equals band bit for bit; a 1 means that output is active.
- R9: With ctrl[5] at 1, band_on[4] carries the reference level and band_on[2] carries fb_half. The other band outputs still follow band, and band[4] and band[2] are ignored.
- R10: During reset both pump enables are low. The first reference terminal count occurs in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_pulse | input | 1 | One-cycle pulse at each feedback divider terminal count |
| fb_half | input | 1 | Feedback divider output divided by two |
| ctrl | input | 7 | Control word: 0 amp off, 1 and 4 detector mode, 2 and 3 ratio select, 5 test route, 6 pump current |
| band | input | 5 | Band selection word |
| pump_up | output | 1 | Up current source enable |
| pump_dn | output | 1 | Down current source enable |
| pump_hi | output | 1 | High pump current select |
| amp_off | output | 1 | Loop amplifier disable |
| band_on | output | 5 | Active band outputs |

## Verification
The hardest case to reach is a feedback pulse that lands in the same cycle as the reference terminal count. This case must cancel rather than leave a one-cycle enable. The reference phase is not a port, so the bench turns on test routing and locks onto the rising edge of the reference on band_on[4]. From that edge it counts the known period down to the terminal-count cycle and fires the feedback pulse there. The same lock is used to change the ratio bits exactly one cycle into a period, which separates the period in progress from the following one.

// File: rtl/pllref_pkg.sv
package pllref_pkg;

  localparam int CTRL_W     = 7;
  localparam int CB_AMP_OFF = 0;
  localparam int CB_DET_A   = 1;
  localparam int CB_RATIO_A = 2;
  localparam int CB_RATIO_B = 3;
  localparam int CB_DET_B   = 4;
  localparam int CB_TEST    = 5;
  localparam int CB_PUMP_HI = 6;

  typedef enum logic [1:0] {
    DET_UP_ONLY = 2'b00,
    DET_DN_ONLY = 2'b01,
    DET_NORMAL  = 2'b10,
    DET_OFF     = 2'b11
  } det_mode_e;

  function automatic det_mode_e decode_mode(input logic det_a, input logic det_b);
    return det_mode_e'({det_a, det_b});
  endfunction

  function automatic logic pick_high_ratio(input logic ra, input logic rb);
    return ra ^ rb;
  endfunction

endpackage

// File: rtl/pllref_ref_div.sv
module pllref_ref_div #(
  parameter int LO_RATIO = 512,
  parameter int HI_RATIO = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_hi,
  output logic ref_tick,
  output logic ref_level
);
  localparam int MAX_R = (HI_RATIO > LO_RATIO) ? HI_RATIO : LO_RATIO;
  localparam int RW    = $clog2(MAX_R + 1);

  logic [RW-1:0] cnt_q, len_q, len_next;

  function automatic logic [RW-1:0] ratio_value(input logic hi);
    return hi ? RW'(HI_RATIO) : RW'(LO_RATIO);
  endfunction

  assign len_next  = ratio_value(sel_hi);
  assign ref_tick  = (cnt_q == '0);
  assign ref_level = (cnt_q >= (len_q >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= RW'(LO_RATIO);
    end else if (ref_tick) begin
      cnt_q <= len_next - RW'(1);
      len_q <= len_next;
    end else begin
      cnt_q <= cnt_q - RW'(1);
    end
  end

  // R2: the active period length changes only at a terminal count
  a_r2_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(len_q));

  // R1: the count stays inside the active period
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len_q);

endmodule

// File: rtl/pllref_pfd.sv
module pllref_pfd
  import pllref_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_tick,
  input  logic      fb_pulse,
  input  det_mode_e mode,
  output logic      pump_up,
  output logic      pump_dn
);
  logic up_q, dn_q, up_pend, dn_pend, meet;

  assign up_pend = up_q | ref_tick;
  assign dn_pend = dn_q | fb_pulse;
  assign meet    = up_pend & dn_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (mode != DET_NORMAL) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_pend & ~meet;
      dn_q <= dn_pend & ~meet;
    end
  end

  always_comb begin
    unique case (mode)
      DET_NORMAL:  begin pump_up = up_q; pump_dn = dn_q; end
      DET_UP_ONLY: begin pump_up = 1'b1; pump_dn = 1'b0; end
      DET_DN_ONLY: begin pump_up = 1'b0; pump_dn = 1'b1; end
      default:     begin pump_up = 1'b0; pump_dn = 1'b0; end
    endcase
  end

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && fb_pulse && !ref_tick) |=> (!up_q && !dn_q));

  a_r3_up_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_NORMAL && ref_tick && !fb_pulse && !dn_q) |=> up_q);

  a_r6_idle_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DET_NORMAL) |=> (!up_q && !dn_q));

endmodule

// File: rtl/pllref_band_route.sv
module pllref_band_route #(
  parameter int BAND_W  = 5,
  parameter int REF_IDX = 4,
  parameter int FB_IDX  = 2
) (
  input  logic              test_en,
  input  logic              ref_level,
  input  logic              fb_half,
  input  logic [BAND_W-1:0] band,
  output logic [BAND_W-1:0] band_on
);
  for (genvar i = 0; i < BAND_W; i++) begin : g_bit
    if (i == REF_IDX) begin : g_ref
      assign band_on[i] = test_en ? ref_level : band[i];
    end else if (i == FB_IDX) begin : g_fb
      assign band_on[i] = test_en ? fb_half : band[i];
    end else begin : g_pass
      assign band_on[i] = band[i];
    end
  end
endmodule

// File: rtl/refpd_ctrl.sv
module refpd_ctrl
  import pllref_pkg::*;
#(
  parameter int LO_RATIO = 512,
  parameter int HI_RATIO = 1024,
  parameter int BAND_W   = 5,
  parameter int REF_IDX  = 4,
  parameter int FB_IDX   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fb_pulse,
  input  logic              fb_half,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [BAND_W-1:0] band,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              pump_hi,
  output logic              amp_off,
  output logic [BAND_W-1:0] band_on
);
  det_mode_e mode;
  logic      sel_hi, ref_tick, ref_level;

  assign mode    = decode_mode(ctrl[CB_DET_A], ctrl[CB_DET_B]);
  assign sel_hi  = pick_high_ratio(ctrl[CB_RATIO_A], ctrl[CB_RATIO_B]);
  assign pump_hi = ctrl[CB_PUMP_HI];
  assign amp_off = ctrl[CB_AMP_OFF];

  pllref_ref_div #(.LO_RATIO(LO_RATIO), .HI_RATIO(HI_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .sel_hi(sel_hi),
    .ref_tick(ref_tick), .ref_level(ref_level)
  );

  pllref_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_pulse(fb_pulse),
    .mode(mode), .pump_up(pump_up), .pump_dn(pump_dn)
  );

  pllref_band_route #(.BAND_W(BAND_W), .REF_IDX(REF_IDX), .FB_IDX(FB_IDX)) u_band (
    .test_en(ctrl[CB_TEST]), .ref_level(ref_level), .fb_half(fb_half),
    .band(band), .band_on(band_on)
  );

  a_r5_forced_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_UP_ONLY) |-> (pump_up && !pump_dn));

  a_r5_forced_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DET_DN_ONLY) |-> (pump_dn && !pump_up));

endmodule

// File: tb/refpd_ctrl_bench.sv
module refpd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LO = 8;
  localparam int HI = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fb_pulse = 1'b0;
  logic       fb_half = 1'b0;
  logic [6:0] ctrl = 7'h02;
  logic [4:0] band = 5'b0;
  logic       pump_up, pump_dn, pump_hi, amp_off;
  logic [4:0] band_on;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refpd_ctrl #(.LO_RATIO(LO), .HI_RATIO(HI)) u_refpd_ctrl (
    .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse), .fb_half(fb_half),
    .ctrl(ctrl), .band(band), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hi(pump_hi), .amp_off(amp_off), .band_on(band_on)
  );

  // {ctrl, band, expected {pump_up, pump_dn, pump_hi, amp_off, band_on}}
  localparam logic [20:0] VEC [7] = '{
    {7'h12, 5'b10101, 9'b0000_10101},
    {7'h00, 5'b00000, 9'b1000_00000},
    {7'h10, 5'b11111, 9'b0100_11111},
    {7'h41, 5'b01010, 9'b1011_01010},
    {7'h53, 5'b00100, 9'b0011_00100},
    {7'h1D, 5'b11000, 9'b0101_11000},
    {7'h5E, 5'b00011, 9'b0010_00011}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk);
    prev = band_on[4];
    forever begin
      @(negedge clk);
      if (band_on[4] && !prev) break;
      prev = band_on[4];
    end
  endtask

  // called on the negedge of a rise; returns on the negedge of the next rise
  task automatic measure(output int per, output int hi);
    logic prev;
    per = 1; hi = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (band_on[4] && !prev) break;
      per++;
      if (band_on[4]) hi++;
      prev = band_on[4];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p, h;
    repeat (3) @(negedge clk);
    chk("R10 up in reset", 16'(pump_up), 16'h0);
    chk("R10 dn in reset", 16'(pump_dn), 16'h0);
    chk("R10 bands in reset", 16'(band_on), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 first tick sets up", 16'({pump_up, pump_dn}), 16'h2);

    for (int i = 0; i < 7; i++) begin
      ctrl = VEC[i][20:14];
      band = VEC[i][13:9];
      @(negedge clk);
      chk($sformatf("R5 R7 R8 vector %0d", i),
          16'({pump_up, pump_dn, pump_hi, amp_off, band_on}), 16'(VEC[i][8:0]));
    end

    // ratio and period via test routing
    ctrl = 7'h22; band = 5'b0;
    wait_rise();
    measure(p, h);
    measure(p, h);
    chk("R1 R9 lo period", 16'(p), 16'(LO));
    chk("R1 R9 lo high", 16'(h), 16'(LO/2));
    ctrl = 7'h26;
    measure(p, h);
    chk("R2 old period kept", 16'(p), 16'(LO));
    chk("R2 old high kept", 16'(h), 16'(LO/2));
    measure(p, h);
    chk("R1 hi period a", 16'(p), 16'(HI));
    chk("R1 hi high a", 16'(h), 16'(HI/2));
    ctrl = 7'h2E;
    measure(p, h);
    chk("R2 old hi period kept", 16'(p), 16'(HI));
    measure(p, h);
    chk("R1 lo period both set", 16'(p), 16'(LO));
    ctrl = 7'h2A;
    measure(p, h);
    measure(p, h);
    chk("R1 hi period b", 16'(p), 16'(HI));
    ctrl = 7'h22;
    measure(p, h);
    measure(p, h);
    chk("R1 lo period restored", 16'(p), 16'(LO));

    // test route of fb_half
    band = 5'b00101; fb_half = 1'b0;
    @(negedge clk);
    chk("R9 route fb low", 16'(band_on[3:0]), 16'h1);
    fb_half = 1'b1;
    @(negedge clk);
    chk("R9 route fb high", 16'(band_on[3:0]), 16'h5);
    band = 5'b0; fb_half = 1'b0;

    // detector sequences, period LO
    wait_rise();
    chk("R3 up after ref", 16'({pump_up, pump_dn}), 16'h2);
    fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    chk("R4 cancel after fb", 16'({pump_up, pump_dn}), 16'h0);
    repeat (LO-2) @(negedge clk);
    fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    chk("R4 same cycle ref edge seen", 16'(band_on[4]), 16'h1);
    chk("R4 same cycle no enable", 16'({pump_up, pump_dn}), 16'h0);
    @(negedge clk); fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    chk("R3 dn after fb", 16'({pump_up, pump_dn}), 16'h1);
    fb_pulse = 1'b1;
    @(negedge clk); fb_pulse = 1'b0;
    chk("R4 repeat fb keeps dn", 16'({pump_up, pump_dn}), 16'h1);
    wait_rise();
    chk("R4 ref clears dn", 16'({pump_up, pump_dn}), 16'h0);
    wait_rise();
    chk("R3 up after next ref", 16'({pump_up, pump_dn}), 16'h2);
    wait_rise();
    chk("R4 repeat ref keeps up", 16'({pump_up, pump_dn}), 16'h2);

    // forced modes
    ctrl = 7'h20;
    @(negedge clk);
    chk("R5 up only", 16'({pump_up, pump_dn}), 16'h2);
    ctrl = 7'h22;
    #1;
    chk("R6 normal starts idle", 16'({pump_up, pump_dn}), 16'h0);
    @(negedge clk);
    chk("R6 still idle", 16'({pump_up, pump_dn}), 16'h0);
    ctrl = 7'h30;
    wait_rise();
    chk("R5 down only over ref", 16'({pump_up, pump_dn}), 16'h1);
    ctrl = 7'h32;
    wait_rise();
    chk("R5 off over ref", 16'({pump_up, pump_dn}), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule